// File: doc/BRIEF.md
# Omega Multistage Interconnect Router

This block connects eight requesters to eight memory ports through a three-stage self-routing network. Each stage is a column of 2x2 switches. A perfect-shuffle permutation, which rotates the port index left by one bit, sits in front of every stage. Each input offers a valid flag, a 3-bit destination label and a payload. Every switch decides for itself whether to pass a message straight or crossed. It bases that choice only on one bit of the message's source label and the matching bit of its destination label.

When two live messages inside one switch want the same switch output, the message on the switch's upper port wins. The other message is dropped and reported. The routing network is purely combinational. Delivered payloads, their valid flags and the per-input blocked flags are captured together in one register stage, so every result appears one clock edge after the inputs are presented. No buffering, retry or flow control is provided. A requester that sees its blocked flag is expected to present the message again later.

Top module: `omega_router`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released with no valid input, every bit of `out_valid` and `blocked` is 0.
- R2: A valid input that meets no conflict appears on output port number `dst` (the 3-bit label, value 0..7) with its payload unchanged, one rising clock edge after it is presented.
- R3: Stage s (s = 0 first) compares source bit 2-s with destination bit 2-s. Equal bits send the message straight and differing bits cross it, so the identity mapping (dst = src) and the complement mapping (dst = 7-src) both deliver all eight messages.
- R4: Each stage is preceded by a perfect shuffle (index rotated left by one bit). As a result, inputs i and i+4 share a first-stage switch and collide when their destinations have the same most significant bit.
- R5: In a collision at any stage, the message on the switch's upper port (the even-numbered position) wins. The losing input's `blocked` bit is 1 in the same cycle that the winner appears at the output.
- R6: A blocked message appears on no output, and an output that receives no message shows `out_valid` = 0.
- R7: An input with `in_valid` = 0 is ignored. It is not delivered, its `blocked` bit stays 0, and it blocks no other message, whatever its destination label holds.
- R8: Every valid input is either delivered or blocked, never both. The number of set `out_valid` bits plus set `blocked` bits equals the number of set `in_valid` bits of the previous cycle.
- R9: Any uniform shift mapping, dst = (src + k) mod 8, delivers all eight messages with no input blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per-input request valid; bit i belongs to input i |
| in_dst | input | 24 | Destination labels; bits [3i+2:3i] belong to input i |
| in_data | input | 128 | Payloads; bits [16i+15:16i] belong to input i |
| out_valid | output | 8 | Registered per-output valid; bit j for output port j |
| out_data | output | 128 | Registered payloads; bits [16j+15:16j] for output port j |
| blocked | output | 8 | Registered per-input blocked flag; bit i for input i |

## Verification
All three results (`out_valid`, `out_data` and `blocked`) belong to the vector presented before the same rising edge, so each is due exactly one edge after the inputs change. The bench drives each vector on a falling edge, lets one rising edge pass, and compares all three at the next falling edge, before any new vector reaches the register. A reset pulse is checked at that same point: the outputs must already be clear in the half cycle after reset is asserted.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect-shuffle: rotate an lg-bit port index left by one position.
  function automatic int shuffle_pos(input int pos, input int lg);
    int mask;
    mask = (1 << lg) - 1;
    return ((pos << 1) | (pos >> (lg - 1))) & mask;
  endfunction

  // A switch crosses when the compared source and destination bits differ.
  function automatic logic route_cross(input logic src_bit, input logic dst_bit);
    return src_bit ^ dst_bit;
  endfunction

  // Label bit examined by a given stage: most significant first.
  function automatic int stage_bit(input int stage, input int lg);
    return lg - 1 - stage;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int LG  = 3,
  parameter int DW  = 16,
  parameter int BIT = 2
) (
  input  logic [1:0]          i_v,
  input  logic [1:0][LG-1:0]  i_src,
  input  logic [1:0][LG-1:0]  i_dst,
  input  logic [1:0][DW-1:0]  i_data,
  output logic [1:0]          o_v,
  output logic [1:0][LG-1:0]  o_src,
  output logic [1:0][LG-1:0]  o_dst,
  output logic [1:0][DW-1:0]  o_data,
  output logic [1:0]          o_drop
);

  // Output port chosen by each input: its own port index, flipped on a cross.
  logic [1:0] sel;
  logic       clash;

  always_comb begin
    sel[0] = 1'b0 ^ route_cross(i_src[0][BIT], i_dst[0][BIT]);
    sel[1] = 1'b1 ^ route_cross(i_src[1][BIT], i_dst[1][BIT]);
  end

  // Both inputs live and aiming at the same output: the upper port keeps it.
  assign clash  = i_v[0] && i_v[1] && (sel[0] == sel[1]);
  assign o_drop = {clash, 1'b0};

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic pick_u;
    logic pick_l;
    assign pick_u    = i_v[0] && (sel[0] == 1'(o));
    assign pick_l    = i_v[1] && (sel[1] == 1'(o)) && !clash;
    assign o_v[o]    = pick_u | pick_l;
    assign o_src[o]  = pick_u ? i_src[0]  : i_src[1];
    assign o_dst[o]  = pick_u ? i_dst[0]  : i_dst[1];
    assign o_data[o] = pick_u ? i_data[0] : i_data[1];
  end

  // Checks on the local switching decision.
  always_comb begin
    if (i_v[0]) a_r4_upper_port: assert (i_src[0][BIT] == 1'b0);
    if (i_v[1]) a_r4_lower_port: assert (i_src[1][BIT] == 1'b1);
    if (i_v[0] && (i_src[0][BIT] == i_dst[0][BIT]))
      a_r3_straight: assert (o_v[0] && (o_src[0] == i_src[0]));
    if (i_v[0] && (i_src[0][BIT] != i_dst[0][BIT]))
      a_r3_cross: assert (o_v[1] && (o_src[1] == i_src[0]));
    if (i_v[1] && !o_drop[1])
      a_r5_lower_survives: assert (o_v[i_dst[1][BIT]] && (o_src[i_dst[1][BIT]] == i_src[1]));
    a_r6_conserve: assert ($countones(o_v) == $countones(i_v) - $countones(o_drop));
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int LG    = 3,
  parameter int DW    = 16,
  parameter int STAGE = 0,
  localparam int P    = 1 << LG
) (
  input  logic [P-1:0]          i_v,
  input  logic [P-1:0][LG-1:0]  i_src,
  input  logic [P-1:0][LG-1:0]  i_dst,
  input  logic [P-1:0][DW-1:0]  i_data,
  output logic [P-1:0]          o_v,
  output logic [P-1:0][LG-1:0]  o_src,
  output logic [P-1:0][LG-1:0]  o_dst,
  output logic [P-1:0][DW-1:0]  o_data,
  output logic [P-1:0]          o_blk
);

  localparam int BIT = stage_bit(STAGE, LG);

  // Lanes after the shuffle wiring, as seen by the switch inputs.
  logic [P-1:0]          sv;
  logic [P-1:0][LG-1:0]  ssrc;
  logic [P-1:0][LG-1:0]  sdst;
  logic [P-1:0][DW-1:0]  sdata;
  logic [P-1:0]          sdrop;

  for (genvar p = 0; p < P; p++) begin : g_shuf
    localparam int Q = shuffle_pos(p, LG);
    assign sv[Q]    = i_v[p];
    assign ssrc[Q]  = i_src[p];
    assign sdst[Q]  = i_dst[p];
    assign sdata[Q] = i_data[p];
  end

  for (genvar k = 0; k < P / 2; k++) begin : g_sw
    omega_switch #(.LG(LG), .DW(DW), .BIT(BIT)) u_sw (
      .i_v    (sv[2*k+1:2*k]),
      .i_src  (ssrc[2*k+1:2*k]),
      .i_dst  (sdst[2*k+1:2*k]),
      .i_data (sdata[2*k+1:2*k]),
      .o_v    (o_v[2*k+1:2*k]),
      .o_src  (o_src[2*k+1:2*k]),
      .o_dst  (o_dst[2*k+1:2*k]),
      .o_data (o_data[2*k+1:2*k]),
      .o_drop (sdrop[2*k+1:2*k])
    );
  end

  // Report each dropped message against the input it came from.
  always_comb begin
    o_blk = '0;
    for (int p = 0; p < P; p++) begin
      if (sdrop[p]) o_blk[ssrc[p]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_router.sv
module omega_router
  import omega_pkg::*;
#(
  parameter int LG = 3,
  parameter int DW = 16,
  localparam int P      = 1 << LG,
  localparam int STAGES = LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P-1:0]      in_valid,
  input  logic [P*LG-1:0]   in_dst,
  input  logic [P*DW-1:0]   in_data,
  output logic [P-1:0]      out_valid,
  output logic [P*DW-1:0]   out_data,
  output logic [P-1:0]      blocked
);

  // Lane state between stages; index 0 is the block input.
  logic [P-1:0]          nv    [STAGES+1];
  logic [P-1:0][LG-1:0]  nsrc  [STAGES+1];
  logic [P-1:0][LG-1:0]  ndst  [STAGES+1];
  logic [P-1:0][DW-1:0]  ndata [STAGES+1];
  logic [P-1:0]          sblk  [STAGES];
  logic [P-1:0]          blk_any;

  for (genvar i = 0; i < P; i++) begin : g_in
    assign nsrc[0][i]  = LG'(i);
    assign ndst[0][i]  = in_dst[i*LG +: LG];
    assign ndata[0][i] = in_data[i*DW +: DW];
  end
  assign nv[0] = in_valid;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    omega_stage #(.LG(LG), .DW(DW), .STAGE(s)) u_stage (
      .i_v    (nv[s]),
      .i_src  (nsrc[s]),
      .i_dst  (ndst[s]),
      .i_data (ndata[s]),
      .o_v    (nv[s+1]),
      .o_src  (nsrc[s+1]),
      .o_dst  (ndst[s+1]),
      .o_data (ndata[s+1]),
      .o_blk  (sblk[s])
    );
  end

  always_comb begin
    blk_any = '0;
    for (int s = 0; s < STAGES; s++) blk_any = blk_any | sblk[s];
  end

  // Output register: one edge of latency for every result.
  logic [P-1:0][DW-1:0] data_q;
  logic                 armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      blocked   <= '0;
      data_q    <= '0;
      armed     <= 1'b0;
    end else begin
      out_valid <= nv[STAGES];
      blocked   <= blk_any;
      data_q    <= ndata[STAGES];
      armed     <= 1'b1;
    end
  end

  assign out_data = data_q;

  // R2 / R7: the last stage lands each message on its own label, from a live input.
  always_comb begin
    for (int j = 0; j < P; j++) begin
      if (nv[STAGES][j]) begin
        a_r2_dest_match: assert (ndst[STAGES][j] == LG'(j));
        a_r7_from_valid: assert (in_valid[nsrc[STAGES][j]]);
      end
    end
  end

  a_r8_accounting: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($countones(out_valid) + $countones(blocked)) == $countones($past(in_valid)));

  a_r7_blk_needs_valid: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (blocked & ~$past(in_valid)) == '0);

endmodule

// File: tb/omega_router_tb.sv
module omega_router_tb;

  localparam int LG = 3;
  localparam int P  = 8;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [P-1:0]      in_valid = '0;
  logic [P*LG-1:0]   in_dst = '0;
  logic [P*DW-1:0]   in_data = '0;
  logic [P-1:0]      out_valid;
  logic [P*DW-1:0]   out_data;
  logic [P-1:0]      blocked;

  omega_router #(.LG(LG), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .blocked(blocked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [P-1:0]         vin;
  int                   dsts [P];
  logic [P-1:0][DW-1:0] din;
  logic [P-1:0]         exp_v;
  logic [P-1:0]         exp_b;
  int                   exp_src [P];

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: track which switch each live message sits in at every stage.
  function automatic void model();
    logic [P-1:0] alive;
    alive = vin;
    exp_b = '0;
    exp_v = '0;
    for (int k = 0; k < P; k++) exp_src[k] = 0;
    for (int s = 0; s < LG; s++) begin
      int claim [2*P];
      int bp;
      bp = LG - 1 - s;
      for (int k = 0; k < 2*P; k++) claim[k] = -1;
      for (int pass = 0; pass < 2; pass++) begin
        for (int src = 0; src < P; src++) begin
          if (alive[3'(src)] && (((src >> bp) & 1) == pass)) begin
            int sw;
            int key;
            sw  = ((src & ((1 << bp) - 1)) << s) | (dsts[src] >> (LG - s));
            key = sw * 2 + ((dsts[src] >> bp) & 1);
            if (claim[key] >= 0) begin
              alive[3'(src)] = 1'b0;
              exp_b[3'(src)] = 1'b1;
            end else begin
              claim[key] = src;
            end
          end
        end
      end
    end
    for (int src = 0; src < P; src++) begin
      if (alive[3'(src)]) begin
        exp_v[3'(dsts[src])] = 1'b1;
        exp_src[dsts[src]]   = src;
      end
    end
  endfunction

  // Drive on a falling edge, let one rising edge register, sample at the next fall.
  task automatic run_vec(input string tag);
    logic [P-1:0][DW-1:0] act_d;
    logic [P-1:0][DW-1:0] exp_d;
    @(negedge clk);
    in_valid = vin;
    for (int i = 0; i < P; i++) in_dst[i*LG +: LG] = 3'(dsts[i]);
    in_data = din;
    model();
    @(posedge clk);
    @(negedge clk);
    check(out_valid == exp_v, {tag, " R2/R6 out_valid"}, 128'(out_valid), 128'(exp_v));
    check(blocked == exp_b, {tag, " R5 blocked"}, 128'(blocked), 128'(exp_b));
    act_d = out_data;
    exp_d = '0;
    for (int j = 0; j < P; j++) begin
      if (!exp_v[3'(j)]) act_d[3'(j)] = '0;
      else exp_d[3'(j)] = din[3'(exp_src[j])];
    end
    check(act_d == exp_d, {tag, " R2 payload"}, act_d, exp_d);
    check(($countones(out_valid) + $countones(blocked)) == $countones(vin),
          {tag, " R8 accounting"}, 128'($countones(out_valid) + $countones(blocked)),
          128'($countones(vin)));
  endtask

  task automatic rand_data();
    for (int i = 0; i < P; i++) din[3'(i)] = DW'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4242));
    vin = '0;
    din = '0;
    for (int i = 0; i < P; i++) dsts[i] = 0;

    // R1: reset holds outputs clear even with inputs active.
    in_valid = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0 && blocked == '0, "R1 during reset",
          128'({out_valid, blocked}), 128'(0));
    in_valid = '0;
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == '0 && blocked == '0, "R1 after release",
          128'({out_valid, blocked}), 128'(0));

    // R3: identity, all switches straight.
    vin = '1; rand_data();
    for (int i = 0; i < P; i++) dsts[i] = i;
    run_vec("R3 identity");
    check(out_valid == '1 && blocked == '0, "R3 identity all delivered",
          128'({out_valid, blocked}), 128'({8'hff, 8'h00}));

    // R3: complement, all switches crossed.
    rand_data();
    for (int i = 0; i < P; i++) dsts[i] = 7 - i;
    run_vec("R3 complement");
    check(out_valid == '1 && blocked == '0, "R3 complement all delivered",
          128'({out_valid, blocked}), 128'({8'hff, 8'h00}));

    // R9: uniform shifts.
    for (int k = 1; k < P; k += 2) begin
      rand_data();
      for (int i = 0; i < P; i++) dsts[i] = (i + k) % P;
      run_vec("R9 shift");
      check(out_valid == '1 && blocked == '0, "R9 shift no blocking",
            128'({out_valid, blocked}), 128'({8'hff, 8'h00}));
    end

    // R4/R5/R6: inputs 0 and 4 meet in the first stage.
    vin = 8'h11; rand_data();
    for (int i = 0; i < P; i++) dsts[i] = 0;
    dsts[0] = 0; dsts[4] = 1;
    run_vec("R4 first-stage pair");
    check(out_valid == 8'h01 && out_data[15:0] == din[0], "R5 upper wins",
          128'({out_valid, out_data[15:0]}), 128'({8'h01, din[0]}));
    check(blocked == 8'h10, "R4 input 4 blocked", 128'(blocked), 128'(8'h10));
    check(out_valid[1] == 1'b0, "R6 loser not delivered", 128'(out_valid), 128'(8'h01));

    // R5: winner decided by port, not by destination value.
    dsts[0] = 1; dsts[4] = 0;
    run_vec("R5 swapped dst");
    check(out_valid == 8'h02 && blocked == 8'h10, "R5 swapped dst",
          128'({out_valid, blocked}), 128'({8'h02, 8'h10}));

    // R5: collision in the second stage (inputs 1 and 3).
    vin = 8'h0a; rand_data();
    dsts[1] = 0; dsts[3] = 1;
    run_vec("R5 second-stage pair");
    check(blocked == 8'h08 && out_valid == 8'h01, "R5 second stage",
          128'({out_valid, blocked}), 128'({8'h01, 8'h08}));

    // R7: invalid input with a colliding label has no effect.
    vin = 8'h10; rand_data();
    dsts[0] = 0; dsts[4] = 1;
    run_vec("R7 invalid ignored");
    check(out_valid == 8'h02 && blocked == 8'h00 && out_data[31:16] == din[4],
          "R7 invalid ignored", 128'({out_valid, blocked, out_data[31:16]}),
          128'({8'h02, 8'h00, din[4]}));
    vin = 8'h00;
    run_vec("R7 all idle");
    check(out_valid == 8'h00 && blocked == 8'h00, "R7 all idle",
          128'({out_valid, blocked}), 128'(0));

    // Random permutations.
    for (int n = 0; n < 150; n++) begin
      for (int i = 0; i < P; i++) dsts[i] = i;
      for (int i = P - 1; i > 0; i--) begin
        int j;
        int t;
        j = int'($urandom_range(i, 0));
        t = dsts[i]; dsts[i] = dsts[j]; dsts[j] = t;
      end
      vin = P'($urandom) | P'($urandom);
      rand_data();
      run_vec("R2 random permutation");
    end

    // Random labels with repeats.
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < P; i++) dsts[i] = int'($urandom_range(P - 1, 0));
      vin = P'($urandom);
      rand_data();
      run_vec("R5 random labels");
    end

    // R1: reset in mid-run clears registered results.
    vin = '1; rand_data();
    for (int i = 0; i < P; i++) dsts[i] = i;
    run_vec("R2 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == '0 && blocked == '0, "R1 mid-run reset",
          128'({out_valid, blocked}), 128'(0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule